// File: doc/BRIEF.md
# Test Access Port Instruction Decoder with User Scan Ports

This block is the instruction side of a test access port. It contains the
sixteen-state TAP controller driven by TMS on the rising edge of TCK, a 3-bit
instruction shift register, the decoded instruction register, a one-flop bypass
register and the falling-edge TDO output stage. The decoded instruction selects
which serial source reaches TDO during Shift-DR. It also raises select strobes for
two user scan chains, for a readback engine and for a configuration engine, and it
drives the boundary-scan mode controls.

The boundary register, the user chains and the readback stream sit outside the
block. Each one is seen as a single serial input that is sampled on the falling
edge of TCK. User logic shifts its own chains with a gated data-register clock.
An active-low idle signal is the NAND of TCK and the Run-Test/Idle state.

Top module: `tap_insn_unit`

## Requirements
- R1: While trst_n is low, tdo and tdo_en are 0 and the instruction is BYPASS, so every select strobe is low. Release is synchronised to two rising TCK edges. Entering Test-Logic-Reset through TMS also forces BYPASS at the next falling edge.
- R2: The TAP controller follows the standard sixteen-state TMS transition graph on rising TCK. dr_capture, dr_shift and dr_update are high exactly in Capture-DR, Shift-DR and Update-DR.
- R3: In Capture-IR the instruction shift register loads binary 001. In Shift-IR it shifts right: TDI enters bit 2 and bit 0 is presented on TDO.
- R4: The decoded instruction changes only on the falling edge of TCK in Update-IR, where it takes the shifted value, or in Test-Logic-Reset. The codes are 000 EXTEST, 001 SAMPLE, 010 USER1, 011 USER2, 100 READBACK, 101 CONFIGURE, 110 reserved and 111 BYPASS.
- R5: For codes 000 and 001, Shift-DR presents bsr_tdo on TDO and bsr_sel is high. bs_extest is high only for 000.
- R6: For 010 or 011, Shift-DR presents usr_tdo1 or usr_tdo2 on TDO and raises sel_usr1 or sel_usr2. At most one of the two select strobes is ever high.
- R7: For 100, Shift-DR presents rdbk_tdo and rdbk_sel is high. For 101, cfg_sel is high and in Shift-DR both tdo_en and tdo are 0.
- R8: For 111 and the reserved 110, the bypass flop loads 0 in Capture-DR and TDI in Shift-DR. TDO shows it one TCK later.
- R9: tdo and tdo_en change only on falling TCK. tdo_en is high only in Shift-IR and Shift-DR, and tdo holds its value outside those states.
- R10: usr_drck follows TCK during its high phase only after a falling edge where the state was Capture-DR or Shift-DR and a user instruction (010 or 011) was active. Otherwise it is 0.
- R11: idle_n is the NAND of TCK and a Run-Test/Idle flag that is latched on falling TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_tdo | input | 1 | Serial out of the boundary register |
| rdbk_tdo | input | 1 | Serial readback stream |
| usr_tdo1 | input | 1 | Serial out of user chain 1 |
| usr_tdo2 | input | 1 | Serial out of user chain 2 |
| sel_usr1 | output | 1 | User chain 1 selected |
| sel_usr2 | output | 1 | User chain 2 selected |
| usr_drck | output | 1 | Gated data-register clock for user chains |
| idle_n | output | 1 | NAND of TCK and Run-Test/Idle |
| bs_extest | output | 1 | Pins driven from the boundary register |
| bsr_sel | output | 1 | Boundary register is the active data register |
| rdbk_sel | output | 1 | Readback engine selected |
| cfg_sel | output | 1 | Configuration engine selected |
| dr_capture | output | 1 | TAP in Capture-DR |
| dr_shift | output | 1 | TAP in Shift-DR |
| dr_update | output | 1 | TAP in Update-DR |

## Verification
All eight instruction codes are loaded in turn, each followed by a nine-bit data scan. The four serial inputs and TDI are fed from one LFSR with different taps, so a wrong TDO source shows up within a few bits. One data scan passes through Pause-DR and Exit2-DR, which separates a correct transition graph from a simplified one. The bypass scans show that the captured zero and the one-cycle delay are right. TMS-only and trst_n resets are applied while a user instruction is active, which shows whether BYPASS is actually forced back. The idle and user-clock outputs are compared in every high phase, so a gate that opens one edge early or late is caught.

// File: rtl/tap_insn_pkg.sv
package tap_insn_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [IR_W-1:0] {
    I_EXTEST   = 3'd0,
    I_SAMPLE   = 3'd1,
    I_USER1    = 3'd2,
    I_USER2    = 3'd3,
    I_READBACK = 3'd4,
    I_CONFIG   = 3'd5,
    I_RSVD     = 3'd6,
    I_BYPASS   = 3'd7
  } insn_t;

  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_insn_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      S_TLR:    state_d = tms ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= S_TLR;
    else        state <= state_d;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_insn_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_lsb,
  output insn_t      insn
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  insn_t           insn_d;
  logic            insn_en;

  always_comb begin
    sr_en = (state == S_CAP_IR) || (state == S_SH_IR);
    sr_d  = (state == S_CAP_IR) ? IR_CAPTURE : {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= IR_CAPTURE;
    else if (sr_en) sr_q <= sr_d;
  end

  always_comb begin
    insn_en = (state == S_TLR) || (state == S_UPD_IR);
    insn_d  = (state == S_TLR) ? I_BYPASS : insn_t'(sr_q);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       insn <= I_BYPASS;
    else if (insn_en) insn <= insn_d;
  end

  assign ir_lsb = sr_q[0];

endmodule

// File: rtl/tap_bypass.sv
module tap_bypass (
  input  logic tck,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic q
);

  logic d, en;

  always_comb begin
    en = capture | shift;
    d  = shift & tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/tap_insn_unit.sv
module tap_insn_unit
  import tap_insn_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bsr_tdo,
  input  logic rdbk_tdo,
  input  logic usr_tdo1,
  input  logic usr_tdo2,
  output logic sel_usr1,
  output logic sel_usr2,
  output logic usr_drck,
  output logic idle_n,
  output logic bs_extest,
  output logic bsr_sel,
  output logic rdbk_sel,
  output logic cfg_sel,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update
);

  logic       rst_meta, rst_n;
  tap_state_t state_q;
  insn_t      insn_q;
  logic       ir_lsb, byp_q;
  logic       tdo_d, tdo_en_d, drck_en_d, rti_d;
  logic       drck_en_q, rti_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state_q));

  tap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .state(state_q), .tdi(tdi),
    .ir_lsb(ir_lsb), .insn(insn_q)
  );

  assign dr_capture = (state_q == S_CAP_DR);
  assign dr_shift   = (state_q == S_SH_DR);
  assign dr_update  = (state_q == S_UPD_DR);

  tap_bypass u_byp (
    .tck(tck), .rst_n(rst_n), .capture(dr_capture), .shift(dr_shift),
    .tdi(tdi), .q(byp_q)
  );

  assign sel_usr1  = (insn_q == I_USER1);
  assign sel_usr2  = (insn_q == I_USER2);
  assign bs_extest = (insn_q == I_EXTEST);
  assign bsr_sel   = (insn_q == I_EXTEST) || (insn_q == I_SAMPLE);
  assign rdbk_sel  = (insn_q == I_READBACK);
  assign cfg_sel   = (insn_q == I_CONFIG);

  always_comb begin
    tdo_d    = tdo;
    tdo_en_d = 1'b0;
    if (state_q == S_SH_IR) begin
      tdo_d    = ir_lsb;
      tdo_en_d = 1'b1;
    end else if (state_q == S_SH_DR) begin
      tdo_en_d = 1'b1;
      unique case (insn_q)
        I_EXTEST, I_SAMPLE: tdo_d = bsr_tdo;
        I_USER1:            tdo_d = usr_tdo1;
        I_USER2:            tdo_d = usr_tdo2;
        I_READBACK:         tdo_d = rdbk_tdo;
        I_CONFIG: begin
          tdo_d    = 1'b0;
          tdo_en_d = 1'b0;
        end
        default:            tdo_d = byp_q;
      endcase
    end
    drck_en_d = (dr_capture || dr_shift) && (sel_usr1 || sel_usr2);
    rti_d     = (state_q == S_RTI);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo       <= 1'b0;
      tdo_en    <= 1'b0;
      drck_en_q <= 1'b0;
      rti_q     <= 1'b0;
    end else begin
      tdo       <= tdo_d;
      tdo_en    <= tdo_en_d;
      drck_en_q <= drck_en_d;
      rti_q     <= rti_d;
    end
  end

  assign usr_drck = tck & drck_en_q;
  assign idle_n   = ~(tck & rti_q);

endmodule

// File: rtl/tap_insn_unit_chk.sv
module tap_insn_unit_chk
  import tap_insn_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input tap_state_t state,
  input insn_t      insn,
  input logic       tdo_en,
  input logic       sel_usr1,
  input logic       sel_usr2,
  input logic       drck_en
);

  a_r1_tlr_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |-> (insn == I_BYPASS));

  a_r4_insn_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !(state inside {S_TLR, S_UPD_IR}) |-> $stable(insn));

  a_r6_sel_onehot: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({sel_usr1, sel_usr2}));

  a_r7_cfg_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_SH_DR && insn == I_CONFIG) |-> !tdo_en);

  a_r9_en_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == S_SH_IR || state == S_SH_DR));

  a_r10_drck_user: assert property (@(posedge tck) disable iff (!trst_n)
    drck_en |-> (sel_usr1 || sel_usr2));

endmodule

bind tap_insn_unit tap_insn_unit_chk u_chk (
  .tck(tck), .trst_n(trst_n), .state(state_q), .insn(insn_q),
  .tdo_en(tdo_en), .sel_usr1(sel_usr1), .sel_usr2(sel_usr2),
  .drck_en(drck_en_q)
);

// File: tb/tap_insn_unit_bench.sv
module tap_insn_unit_bench;

  localparam int TCK_PERIOD = 20;
  localparam int WATCHDOG   = 200000;

  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PAUDR = 6, EX2DR = 7, UPDDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PAUIR = 13, EX2IR = 14, UPDIR = 15;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic bsr_tdo = 1'b0, rdbk_tdo = 1'b0, usr_tdo1 = 1'b0, usr_tdo2 = 1'b0;
  logic tdo, tdo_en, sel_usr1, sel_usr2, usr_drck, idle_n;
  logic bs_extest, bsr_sel, rdbk_sel, cfg_sel, dr_capture, dr_shift, dr_update;

  int n_checks = 0, n_err = 0;
  logic [15:0] lfsr = 16'hACE1;

  int   m_st;
  logic [2:0] m_ir, m_insn;
  logic m_byp, m_tdo, m_en, m_drck, m_rti;

  always #(TCK_PERIOD/2) tck = ~tck;

  tap_insn_unit u_tap_insn_unit (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_tdo(bsr_tdo), .rdbk_tdo(rdbk_tdo), .usr_tdo1(usr_tdo1), .usr_tdo2(usr_tdo2),
    .sel_usr1(sel_usr1), .sel_usr2(sel_usr2), .usr_drck(usr_drck), .idle_n(idle_n),
    .bs_extest(bs_extest), .bsr_sel(bsr_sel), .rdbk_sel(rdbk_sel), .cfg_sel(cfg_sel),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int s, input logic t);
    case (s)
      TLR:   return t ? TLR   : RTI;
      RTI:   return t ? SELDR : RTI;
      SELDR: return t ? SELIR : CAPDR;
      CAPDR: return t ? EX1DR : SHDR;
      SHDR:  return t ? EX1DR : SHDR;
      EX1DR: return t ? UPDDR : PAUDR;
      PAUDR: return t ? EX2DR : PAUDR;
      EX2DR: return t ? UPDDR : SHDR;
      UPDDR: return t ? SELDR : RTI;
      SELIR: return t ? TLR   : CAPIR;
      CAPIR: return t ? EX1IR : SHIR;
      SHIR:  return t ? EX1IR : SHIR;
      EX1IR: return t ? UPDIR : PAUIR;
      PAUIR: return t ? EX2IR : PAUIR;
      EX2IR: return t ? UPDIR : SHIR;
      default: return t ? SELDR : RTI;
    endcase
  endfunction

  function automatic string tdo_tag();
    if (m_st == SHIR) return "R3";
    if (m_st != SHDR) return "R9";
    case (m_insn)
      3'd0, 3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic model_reset();
    m_st = TLR; m_ir = 3'b001; m_insn = 3'b111; m_byp = 1'b0;
    m_tdo = 1'b0; m_en = 1'b0; m_drck = 1'b0; m_rti = 1'b0;
  endtask

  task automatic model_rise();
    if (m_st == CAPIR) m_ir = 3'b001;
    else if (m_st == SHIR) m_ir = {tdi, m_ir[2:1]};
    if (m_st == CAPDR) m_byp = 1'b0;
    else if (m_st == SHDR) m_byp = tdi;
    m_st = nxt(m_st, tms);
  endtask

  task automatic model_fall();
    m_en = 1'b0;
    if (m_st == SHIR) begin m_tdo = m_ir[0]; m_en = 1'b1; end
    else if (m_st == SHDR) begin
      m_en = 1'b1;
      case (m_insn)
        3'd0, 3'd1: m_tdo = bsr_tdo;
        3'd2:       m_tdo = usr_tdo1;
        3'd3:       m_tdo = usr_tdo2;
        3'd4:       m_tdo = rdbk_tdo;
        3'd5:       begin m_tdo = 1'b0; m_en = 1'b0; end
        default:    m_tdo = m_byp;
      endcase
    end
    m_drck = (m_st == CAPDR || m_st == SHDR) && (m_insn == 3'd2 || m_insn == 3'd3);
    m_rti  = (m_st == RTI);
    if (m_st == TLR) m_insn = 3'b111;
    else if (m_st == UPDIR) m_insn = m_ir;
  endtask

  task automatic check_low_phase();
    chk(tdo_tag(), "tdo", tdo, m_tdo);
    chk("R9", "tdo_en", tdo_en, m_en);
    chk("R6", "sel_usr1", sel_usr1, m_insn == 3'd2);
    chk("R6", "sel_usr2", sel_usr2, m_insn == 3'd3);
    chk("R5", "bs_extest", bs_extest, m_insn == 3'd0);
    chk("R5", "bsr_sel", bsr_sel, m_insn <= 3'd1);
    chk("R7", "rdbk_sel", rdbk_sel, m_insn == 3'd4);
    chk("R7", "cfg_sel", cfg_sel, m_insn == 3'd5);
    chk("R2", "dr_capture", dr_capture, m_st == CAPDR);
    chk("R2", "dr_shift", dr_shift, m_st == SHDR);
    chk("R2", "dr_update", dr_update, m_st == UPDDR);
    chk("R11", "idle_n_low_phase", idle_n, 1'b1);
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input logic t, input logic d);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tms = t; tdi = d;
    bsr_tdo = lfsr[1]; rdbk_tdo = lfsr[4]; usr_tdo1 = lfsr[7]; usr_tdo2 = lfsr[11];
    @(posedge tck); #1;
    chk("R11", "idle_n", idle_n, !m_rti);
    chk("R10", "usr_drck", usr_drck, m_drck);
    model_rise();
    @(negedge tck); model_fall(); #1;
    check_low_phase();
    #1;
  endtask

  task automatic load_ir(input logic [2:0] code);
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, code[0]); step(1'b0, code[1]); step(1'b1, code[2]);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input bit pause);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, lfsr[9]);
      if (pause && i == 3) begin
        step(1'b1, lfsr[2]); step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
      end
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic apply_reset();
    @(negedge tck); #2;
    trst_n = 1'b0; tms = 1'b1;
    #1;
    model_reset();
    chk("R1", "reset tdo", tdo, 1'b0);
    chk("R1", "reset tdo_en", tdo_en, 1'b0);
    chk("R1", "reset sel_usr1", sel_usr1, 1'b0);
    chk("R1", "reset sel_usr2", sel_usr2, 1'b0);
    chk("R1", "reset bsr_sel", bsr_sel, 1'b0);
    chk("R1", "reset cfg_sel", cfg_sel, 1'b0);
    repeat (2) @(negedge tck);
    #2 trst_n = 1'b1;
    @(negedge tck); #2;
    repeat (4) step(1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge tck);
    n_err++; n_checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    logic [2:0] order [8] = '{3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    model_reset();
    apply_reset();
    foreach (order[k]) begin
      load_ir(order[k]);
      scan_dr(9, k == 2);
    end
    // R1: TMS-only reset while USER1 is active returns to BYPASS
    load_ir(3'd2);
    repeat (5) step(1'b1, 1'b0);
    chk("R1", "tms reset sel_usr1", sel_usr1, 1'b0);
    scan_dr(5, 1'b0);
    // R1: asynchronous reset while USER2 is active
    load_ir(3'd3);
    scan_dr(4, 1'b0);
    apply_reset();
    scan_dr(6, 1'b1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule